// File: doc/BRIEF.md
# Bus-Activity Watchdog Timer

This block supervises a host processor by watching its two-wire serial bus. The host keeps the block quiet by issuing bus traffic. A START condition followed later by a STOP condition restarts a timeout counter. The shortest sequence that does this is start, clock low, clock high, stop. Any normal read or write transfer to any target also restarts the counter, because every such transfer opens with a START and closes with a STOP. If the counter runs out before the next restart, the block raises a reset request for the rest of the system.

The counter advances only on cycles where a prescaler enable is high, so each timeout is counted in prescaler ticks. A two-bit control field selects one of three periods, and each period is a parameter. The fourth encoding turns the watchdog off. The control field is loaded through a plain write strobe. A write-protect input, while high, blocks every write to the field. The serial lines are asynchronous to the system clock. Each line passes through a two-flop synchronizer before the block looks for edges.

Top module: `bus_watchdog`

## Requirements
- R1: While `rst_n` is low and after it is released, `rst_req` is low, the control field holds `RESET_SEL` (default 2'b00), the counter is zero and no START is pending.
- R2: Each serial line passes through two flops. A START is SDA going 1 to 0 with SCL at 1 in both synchronized samples. A STOP is SDA going 0 to 1 under the same SCL condition. A STOP driven at the pins acts on the timer at the third rising clock edge.
- R3: A STOP restarts the timer only if a START was seen after the previous STOP. A STOP with no START before it leaves the counter and `rst_req` unchanged.
- R4: A restart clears the counter and drops `rst_req`.
- R5: The counter advances by one only on a clock edge where `tick_en` is 1.
- R6: Field value 2'b00 selects `PERIOD0` ticks, 2'b01 selects `PERIOD1` and 2'b10 selects `PERIOD2`. `rst_req` rises on the edge of the N-th tick after the last restart, where N is the selected period.
- R7: Field value 2'b11 disables the watchdog. The counter is held at zero and no new request is raised, but a request that is already high stays high.
- R8: Once high, `rst_req` stays high until a restart or until `rst_n` is asserted. The counter holds at zero while the request is high.
- R9: A write with `cfg_wr_en`=1 and `wp`=0 loads `cfg_wr_data` into the field, and the new value takes effect from the next clock. While `wp`=1, writes leave the field unchanged.
- R10: When a restart and a tick fall on the same edge, the restart wins and the counter becomes zero.
- R11: If the field switches to a period that is shorter than the current count, the next tick raises `rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sda_in | input | 1 | Serial data line, asynchronous |
| scl_in | input | 1 | Serial clock line, asynchronous |
| tick_en | input | 1 | Prescaler enable; one counter step per high cycle |
| cfg_wr_en | input | 1 | Strobe to write the period select field |
| cfg_wr_data | input | 2 | New period select value |
| wp | input | 1 | Write protect for the period select field |
| rst_req | output | 1 | Reset request, sticky until a restart or a reset |

## Verification
The assertions assume that `tick_en`, `cfg_wr_en`, `cfg_wr_data` and `wp` are synchronous to `clk`. They also assume that SDA and SCL never change in the same cycle, so that a START or STOP is never ambiguous. The stimulus drives every input just after the falling clock edge. It changes only one serial line per step and holds each line level for several cycles. The stimulus also covers a STOP with no START before it, a full byte transfer, a locked write, the disabled encoding and a period shrink while the counter is partway through a count.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  // period select encodings
  typedef enum logic [1:0] {
    SEL_P0  = 2'b00,
    SEL_P1  = 2'b01,
    SEL_P2  = 2'b10,
    SEL_OFF = 2'b11
  } wd_sel_e;
endpackage

// File: rtl/bwd_sync.sv
module bwd_sync #(
  parameter int          W         = 2,
  parameter int          STAGES    = 2,
  parameter logic [W-1:0] IDLE_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= IDLE_VAL;
    else        stage_q[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= IDLE_VAL;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/bwd_detect.sv
module bwd_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_s,
  input  logic scl_s,
  output logic kick
);
  logic sda_d, scl_d, armed;
  logic bus_hi, start_det, stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_d <= 1'b1;
      scl_d <= 1'b1;
    end else begin
      sda_d <= sda_s;
      scl_d <= scl_s;
    end
  end

  assign bus_hi    = scl_s & scl_d;
  assign start_det = bus_hi & sda_d & ~sda_s;
  assign stop_det  = bus_hi & ~sda_d & sda_s;
  assign kick      = stop_det & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed <= 1'b0;
    else if (start_det) armed <= 1'b1;
    else if (stop_det)  armed <= 1'b0;
  end

  // R3
  armed_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(sda_d) && !$past(sda_s) && $past(scl_s));

  // R3
  stop_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !armed);
endmodule

// File: rtl/bwd_cfg.sv
module bwd_cfg
  import bwd_pkg::*;
#(
  parameter logic [1:0] RESET_SEL = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  input  logic       wp,
  output wd_sel_e    sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sel <= wd_sel_e'(RESET_SEL);
    else if (wr_en && !wp)   sel <= wd_sel_e'(wr_data);
  end

  // R9
  wp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp |=> sel == $past(sel));
endmodule

// File: rtl/bwd_timer.sv
module bwd_timer
  import bwd_pkg::*;
#(
  parameter int PERIOD0 = 16,
  parameter int PERIOD1 = 64,
  parameter int PERIOD2 = 256,
  parameter int CW      = 9
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    kick,
  input  logic    tick_en,
  input  wd_sel_e sel,
  output logic    rst_req
);
  logic [CW-1:0] count, limit_m1;

  always_comb begin
    case (sel)
      SEL_P0:  limit_m1 = CW'(PERIOD0 - 1);
      SEL_P1:  limit_m1 = CW'(PERIOD1 - 1);
      SEL_P2:  limit_m1 = CW'(PERIOD2 - 1);
      default: limit_m1 = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      rst_req <= 1'b0;
    end else if (kick) begin
      count   <= '0;
      rst_req <= 1'b0;
    end else if (sel == SEL_OFF) begin
      count   <= '0;
    end else if (tick_en && !rst_req) begin
      if (count >= limit_m1) begin
        count   <= '0;
        rst_req <= 1'b1;
      end else begin
        count   <= count + 1'b1;
      end
    end
  end

  // R4
  kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !rst_req && count == '0);

  // R7
  off_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel == SEL_OFF |=> count == '0 && !$rose(rst_req));

  // R8
  req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req && !kick |=> rst_req);

  // R5
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(tick_en));

  // R5
  no_tick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !kick && sel != SEL_OFF |=> $stable(count));
endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
  import bwd_pkg::*;
#(
  parameter int         PERIOD0   = 16,
  parameter int         PERIOD1   = 64,
  parameter int         PERIOD2   = 256,
  parameter logic [1:0] RESET_SEL = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_in,
  input  logic       scl_in,
  input  logic       tick_en,
  input  logic       cfg_wr_en,
  input  logic [1:0] cfg_wr_data,
  input  logic       wp,
  output logic       rst_req
);
  localparam int MAX01 = (PERIOD0 > PERIOD1) ? PERIOD0 : PERIOD1;
  localparam int MAXP  = (MAX01 > PERIOD2) ? MAX01 : PERIOD2;
  localparam int CW    = $clog2(MAXP + 1);

  logic [1:0] lines_s;
  logic       kick;
  wd_sel_e    sel;

  bwd_sync #(.W(2), .STAGES(2), .IDLE_VAL(2'b11)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({sda_in, scl_in}),
    .d_sync  (lines_s)
  );

  bwd_detect u_detect (
    .clk   (clk),
    .rst_n (rst_n),
    .sda_s (lines_s[1]),
    .scl_s (lines_s[0]),
    .kick  (kick)
  );

  bwd_cfg #(.RESET_SEL(RESET_SEL)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .wp      (wp),
    .sel     (sel)
  );

  bwd_timer #(.PERIOD0(PERIOD0), .PERIOD1(PERIOD1), .PERIOD2(PERIOD2), .CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .kick    (kick),
    .tick_en (tick_en),
    .sel     (sel),
    .rst_req (rst_req)
  );
endmodule

// File: tb/test_bus_watchdog.sv
module test_bus_watchdog;
  localparam int P0 = 8, P1 = 20, P2 = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sda = 1'b1, scl = 1'b1, tick = 1'b1, wr_en = 1'b0, wp = 1'b0;
  logic [1:0] wr_data = 2'b00;
  logic rst_req;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_watchdog #(.PERIOD0(P0), .PERIOD1(P1), .PERIOD2(P2)) i_bus_watchdog (
    .clk(clk), .rst_n(rst_n), .sda_in(sda), .scl_in(scl), .tick_en(tick),
    .cfg_wr_en(wr_en), .cfg_wr_data(wr_data), .wp(wp), .rst_req(rst_req)
  );

  // behavioural reference model
  int q_sda[$], q_scl[$];
  int m_cnt, m_sel, m_lim;
  bit m_req, m_armed, m_hi, m_st, m_sp, m_kick;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_sda = '{1, 1, 1}; q_scl = '{1, 1, 1};
      m_cnt = 0; m_sel = 0; m_req = 0; m_armed = 0;
    end else begin
      // q[1] = second sync stage, q[2] = delayed copy
      m_hi = q_scl[1] == 1 && q_scl[2] == 1;
      m_st = m_hi && q_sda[2] == 1 && q_sda[1] == 0;
      m_sp = m_hi && q_sda[2] == 0 && q_sda[1] == 1;
      m_kick = m_sp && m_armed;
      m_lim = (m_sel == 0) ? P0 : (m_sel == 1) ? P1 : P2;
      if (m_kick) begin m_cnt = 0; m_req = 0; end
      else if (m_sel == 3) m_cnt = 0;
      else if (tick && !m_req) begin
        if (m_cnt >= m_lim - 1) begin m_req = 1; m_cnt = 0; end
        else m_cnt++;
      end
      if (m_st) m_armed = 1; else if (m_sp) m_armed = 0;
      if (wr_en && !wp) m_sel = int'(wr_data);
      q_sda.push_front(int'(sda)); void'(q_sda.pop_back());
      q_scl.push_front(int'(scl)); void'(q_scl.pop_back());
    end
  end

  // per-clock comparison (R4 R5 R6 R7 R8 R10 R11 timing)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rst_req !== m_req) begin
        fails++;
        $display("FAIL R6 per-clock compare t=%0t actual=%0b expected=%0b", $time, rst_req, m_req);
      end
    end
  end

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic lines(input logic d, input logic c);
    sda = d; scl = c; step(3);
  endtask

  task automatic kick_min();
    lines(1, 1); lines(0, 1); lines(0, 0); lines(0, 1); lines(1, 1);
  endtask

  task automatic lone_stop();
    lines(1, 1); lines(1, 0); lines(0, 0); lines(0, 1); lines(1, 1);
  endtask

  task automatic byte_xfer(input logic [7:0] b);
    lines(1, 1); lines(0, 1); lines(0, 0);
    for (int i = 7; i >= -1; i--) begin
      lines((i >= 0) ? b[i] : 1'b0, 0);
      lines(sda, 1);
      lines(sda, 0);
    end
    lines(0, 0); lines(0, 1); lines(1, 1);
  endtask

  task automatic write_sel(input logic [1:0] v, input logic lock);
    wp = lock; wr_data = v; wr_en = 1'b1; step(1);
    wr_en = 1'b0; wp = 1'b0; step(1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog R4 actual=hang expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    step(4);
    check(rst_req, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    step(1);
    check(rst_req, 1'b0, "R1 after release");

    step(P0 - 3);
    check(rst_req, 1'b0, "R6 before P0 expiry");
    step(4);
    check(rst_req, 1'b1, "R6 P0 expiry");
    step(30);
    check(rst_req, 1'b1, "R8 request sticky");

    lone_stop(); step(5);
    check(rst_req, 1'b1, "R3 lone stop ignored");

    kick_min(); step(1);
    check(rst_req, 1'b0, "R4 R2 minimal kick clears");

    tick = 1'b0; step(100);
    check(rst_req, 1'b0, "R5 no ticks no expiry");
    for (int i = 0; i < 3 * P0 + 6; i++) begin tick = (i % 3 == 0); step(1); end
    tick = 1'b1;
    check(rst_req, 1'b1, "R5 sparse ticks expiry");

    write_sel(2'b01, 1'b1);
    kick_min(); step(P0 + 4);
    check(rst_req, 1'b1, "R9 locked write ignored");

    write_sel(2'b01, 1'b0);
    kick_min(); step(P0 + 2);
    check(rst_req, 1'b0, "R6 P1 not yet");
    step(P1);
    check(rst_req, 1'b1, "R6 P1 expiry");

    write_sel(2'b10, 1'b0);
    byte_xfer(8'hA5); step(P1 + 2);
    check(rst_req, 1'b0, "R3 byte transfer kick, P2 pending");
    step(P2);
    check(rst_req, 1'b1, "R6 P2 expiry");

    write_sel(2'b11, 1'b0); step(60);
    check(rst_req, 1'b1, "R7 held request while off");
    kick_min(); step(150);
    check(rst_req, 1'b0, "R7 off no expiry");

    write_sel(2'b10, 1'b0); step(30);
    check(rst_req, 1'b0, "R11 midway in P2");
    write_sel(2'b00, 1'b0); step(1);
    check(rst_req, 1'b1, "R11 shrink expires");

    kick_min(); step(P0 - 4);
    check(rst_req, 1'b0, "R10 kick wins over tick");

    step(20);
    rst_n = 1'b0; step(2);
    check(rst_req, 1'b0, "R1 reset clears request");
    rst_n = 1'b1; step(5);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule